// File: doc/BRIEF.md
# Synchronizable PWM Time-Base Counter

This block is the time base of one PWM channel. A counter steps once per enabled clock cycle and turns around at a programmable period. It runs in one of two shapes: a sawtooth that climbs to the period and falls back to zero, or a triangle that climbs to the period and then descends to zero. The period is written into a shadow register. A selectable moment copies the shadow into the active period: the zero point, the synchronization event, or the write itself.

Several instances are chained so that their counters stay in step. The leading instance emits a one-cycle sync pulse each time its counter is at zero. A following instance takes that pulse on `sync_in`. It can forward the pulse unchanged on its own `sync_out` to the next stage. When phase loading is enabled, the received pulse replaces the counter value with a programmed phase. In triangle mode it also picks the direction that follows. The receive path has a fixed latency of `SYNC_LAT` cycles from `sync_in` to the counter output. A follower with phase `SYNC_LAT` therefore runs in exact step with its leader, and a follower with phase 0 trails it by a constant `SYNC_LAT` cycles. A common `run_en` freezes every counter while low, so chained instances start on the same cycle.

The counter is a two-state machine. In ST_UP the count rises. ST_UP moves to ST_DOWN when the count reaches the active period in triangle mode. In ST_DOWN the count falls, and ST_DOWN moves back to ST_UP when the count reaches zero. A phase load forces ST_DOWN when the direction bit asks for it in triangle mode, and ST_UP otherwise. Sawtooth mode always holds ST_UP.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low, `count` becomes 0 and the active period becomes `DEF_PRD`. While `run_en` is low, `zero_evt` and `prd_evt` stay 0.
- R2: While `run_en` is low, `count` keeps its value. This includes sync pulses and shadow transfers that arrive in that time.
- R3: With `cnt_mode` = 0 (sawtooth), the count rises by one per cycle. After the cycle where it is at or above the active period, it returns to 0, so a period P repeats every P+1 cycles.
- R4: With `cnt_mode` = 1 (triangle), the count rises to the active period P and then falls to 0, one step per cycle, so the pattern repeats every 2P cycles.
- R5: `zero_evt` is high exactly in the enabled cycles where `count` is 0. `prd_evt` is high exactly in the enabled cycles where `count` equals the active period.
- R6: `prd_wr` stores `prd_din` in the shadow period. `prd_ld_sel` sets when the active period takes it. With 0, the shadow is copied at the clock edge that ends an enabled cycle with `count` = 0. With 1, it is copied at the edge where a received sync takes effect. With 2, the written value becomes active at the edge of the write.
- R7: With `phs_en` = 1, a `sync_in` pulse in cycle T makes `count` equal `phs_val` in cycle T+`SYNC_LAT`.
- R8: With `phs_en` = 0, a `sync_in` pulse leaves the count sequence unchanged.
- R9: In triangle mode, `phs_dir_dn` = 1 makes the count fall after a phase load, and 0 makes it rise.
- R10: `so_sel` sets what drives `sync_out`. With 1, `sync_out` follows `zero_evt`. With 2, it follows `sync_in` in the same cycle. With 0, it is held at 0.
- R11: A leader with `so_sel` = 1 drives a follower's `sync_in`, and both start together on `run_en`. With `phs_en` = 1 on the follower, phase `SYNC_LAT` keeps the two counts equal on every cycle in both modes. Phase 0 makes the follower's count equal the leader's count from `SYNC_LAT` cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global count enable; low freezes the counter |
| cnt_mode | input | 1 | 0 sawtooth, 1 triangle |
| prd_wr | input | 1 | Write strobe for the shadow period |
| prd_din | input | W | Period value to write |
| prd_ld_sel | input | 2 | Shadow transfer point: 0 zero, 1 sync, 2 at write |
| phs_en | input | 1 | Enables phase loading on received sync |
| phs_val | input | W | Phase value loaded on sync |
| phs_dir_dn | input | 1 | Triangle mode: 1 count down after a phase load |
| so_sel | input | 2 | Sync-out source: 0 off, 1 zero, 2 pass-through |
| sync_in | input | 1 | Incoming sync pulse |
| count | output | W | Counter value |
| zero_evt | output | 1 | One-cycle strobe at count zero |
| prd_evt | output | 1 | One-cycle strobe at count equal to period |
| sync_out | output | 1 | Outgoing sync pulse |

## Verification
The properties assume that `sync_in` pulses are one cycle wide. They also assume that a phase load and the decision for the next step are both made from the value seen in the current cycle. The checks on stepping and turning are therefore gated off in any cycle where a received sync takes effect. The stimulus keeps every sync pulse to a single cycle and writes the period only at defined moments. It starts chained instances from a common reset with `run_en` rising in one cycle, so that the leader's first zero is the cycle where counting starts.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    typedef enum logic {
        CM_SAW = 1'b0,
        CM_TRI = 1'b1
    } cnt_mode_e;

    typedef enum logic [1:0] {
        SO_OFF  = 2'd0,
        SO_ZERO = 2'd1,
        SO_PASS = 2'd2
    } so_sel_e;

    typedef enum logic [1:0] {
        PL_ZERO   = 2'd0,
        PL_SYNC   = 2'd1,
        PL_DIRECT = 2'd2
    } prd_ld_e;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } dir_st_e;

endpackage

// File: rtl/pwm_sync_rx.sv
// Receive path for the sync pulse. Together with the counter register it
// makes LAT register stages from sync_in to the counter output.
module pwm_sync_rx #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_eff
);
    localparam int STAGES = (LAT > 1) ? LAT - 1 : 0;

    generate
        if (STAGES == 0) begin : g_direct
            assign sync_eff = sync_in;
        end else begin : g_pipe
            logic [STAGES-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q[0] <= sync_in;
                    for (int i = 1; i < STAGES; i++) begin
                        pipe_q[i] <= pipe_q[i-1];
                    end
                end
            end
            assign sync_eff = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pwm_prd_shadow.sv
module pwm_prd_shadow
    import pwm_timebase_pkg::*;
#(
    parameter int          W       = 16,
    parameter logic [W-1:0] DEF_PRD = 16'd100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  prd_ld_e      sel,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         at_zero,
    input  logic         sync_evt,
    output logic [W-1:0] act_prd
);
    logic [W-1:0] shd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q   <= DEF_PRD;
            act_prd <= DEF_PRD;
        end else begin
            if (wr) begin
                shd_q <= din;
            end
            unique case (sel)
                PL_ZERO:   if (run && at_zero)  act_prd <= shd_q;
                PL_SYNC:   if (run && sync_evt) act_prd <= shd_q;
                PL_DIRECT: if (wr)              act_prd <= din;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_timebase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] prd,
    input  logic         load,
    input  logic [W-1:0] phs,
    input  logic         dir_dn,
    output logic [W-1:0] cnt,
    output logic         zero,
    output logic         top
);
    localparam logic [W-1:0] ONE = W'(1);

    dir_st_e      st_q, st_n;
    logic [W-1:0] cnt_q, cnt_n;

    // next-state and next-count logic
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (!run) begin
            st_n  = st_q;
            cnt_n = cnt_q;
        end else if (load) begin
            cnt_n = phs;
            st_n  = (mode == CM_TRI && dir_dn) ? ST_DOWN : ST_UP;
        end else if (mode == CM_SAW) begin
            st_n  = ST_UP;
            cnt_n = (cnt_q >= prd) ? '0 : cnt_q + ONE;
        end else begin
            unique case (st_q)
                ST_UP: begin
                    if (cnt_q >= prd) begin
                        st_n  = ST_DOWN;
                        cnt_n = (cnt_q == '0) ? '0 : cnt_q - ONE;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                ST_DOWN: begin
                    if (cnt_q == '0) begin
                        st_n  = ST_UP;
                        cnt_n = (prd == '0) ? '0 : ONE;
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        cnt  = cnt_q;
        zero = run && (cnt_q == '0);
        top  = run && (cnt_q == prd);
    end
endmodule

// File: rtl/pwm_sync_out.sv
module pwm_sync_out
    import pwm_timebase_pkg::*;
(
    input  so_sel_e sel,
    input  logic    zero,
    input  logic    sync_in,
    output logic    sync_out
);
    always_comb begin
        unique case (sel)
            SO_ZERO: sync_out = zero;
            SO_PASS: sync_out = sync_in;
            default: sync_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           SYNC_LAT = 2,
    parameter logic [W-1:0] DEF_PRD  = 16'd100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         cnt_mode,
    input  logic         prd_wr,
    input  logic [W-1:0] prd_din,
    input  logic [1:0]   prd_ld_sel,
    input  logic         phs_en,
    input  logic [W-1:0] phs_val,
    input  logic         phs_dir_dn,
    input  logic [1:0]   so_sel,
    input  logic         sync_in,
    output logic [W-1:0] count,
    output logic         zero_evt,
    output logic         prd_evt,
    output logic         sync_out
);
    logic         sync_eff;
    logic [W-1:0] act_prd;

    pwm_sync_rx #(.LAT(SYNC_LAT)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .sync_eff (sync_eff)
    );

    pwm_prd_shadow #(.W(W), .DEF_PRD(DEF_PRD)) u_prd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .sel      (prd_ld_e'(prd_ld_sel)),
        .wr       (prd_wr),
        .din      (prd_din),
        .at_zero  (zero_evt),
        .sync_evt (sync_eff),
        .act_prd  (act_prd)
    );

    pwm_tb_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .mode   (cnt_mode_e'(cnt_mode)),
        .prd    (act_prd),
        .load   (sync_eff && phs_en),
        .phs    (phs_val),
        .dir_dn (phs_dir_dn),
        .cnt    (count),
        .zero   (zero_evt),
        .top    (prd_evt)
    );

    pwm_sync_out u_so (
        .sel      (so_sel_e'(so_sel)),
        .zero     (zero_evt),
        .sync_in  (sync_in),
        .sync_out (sync_out)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic         cnt_mode,
    input logic         phs_en,
    input logic [W-1:0] phs_val,
    input logic [1:0]   so_sel,
    input logic         sync_eff,
    input logic [W-1:0] act_prd,
    input logic [W-1:0] count,
    input logic         sync_out
);
    localparam logic [W-1:0] ONE = W'(1);

    // R2
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(count));

    // R3
    saw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !cnt_mode && !(sync_eff && phs_en) && count < act_prd)
        |=> (count == $past(count) + ONE));

    // R4
    tri_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_mode && !(sync_eff && phs_en) && count == act_prd && count != '0)
        |=> (count == $past(count) - ONE));

    // R7
    phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && phs_en && sync_eff) |=> (count == $past(phs_val)));

    // R8
    no_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !phs_en && sync_eff && !cnt_mode && count < act_prd)
        |=> (count == $past(count) + ONE));

    // R10
    so_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_sel == 2'd1 && sync_out) |-> (count == '0 && run_en));
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .cnt_mode (cnt_mode),
    .phs_en   (phs_en),
    .phs_val  (phs_val),
    .so_sel   (so_sel),
    .sync_eff (sync_eff),
    .act_prd  (act_prd),
    .count    (count),
    .sync_out (sync_out)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
    localparam int W   = 8;
    localparam int LAT = 2;
    localparam int P   = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n, run_en, cnt_mode, prd_wr, phs_en, phs_dir_dn, tb_sync, chain;
    logic [W-1:0] prd_din, phs_val;
    logic [1:0]   prd_ld_sel, so_sel;
    logic [W-1:0] count, m_count;
    logic         zero_evt, prd_evt, sync_out;
    logic         m_zero, m_prd, m_sync;

    pwm_timebase #(.W(W), .SYNC_LAT(LAT), .DEF_PRD(W'(P))) u_mst (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_mode(cnt_mode),
        .prd_wr(1'b0), .prd_din('0), .prd_ld_sel(2'd0), .phs_en(1'b0),
        .phs_val('0), .phs_dir_dn(1'b0), .so_sel(2'd1), .sync_in(1'b0),
        .count(m_count), .zero_evt(m_zero), .prd_evt(m_prd), .sync_out(m_sync)
    );

    pwm_timebase #(.W(W), .SYNC_LAT(LAT), .DEF_PRD(W'(P))) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_mode(cnt_mode),
        .prd_wr(prd_wr), .prd_din(prd_din), .prd_ld_sel(prd_ld_sel),
        .phs_en(phs_en), .phs_val(phs_val), .phs_dir_dn(phs_dir_dn),
        .so_sel(so_sel), .sync_in(chain ? m_sync : tb_sync),
        .count(count), .zero_evt(zero_evt), .prd_evt(prd_evt), .sync_out(sync_out)
    );

    typedef struct {
        int    cyc;
        int    sig;
        int    exp;
        string req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc++;

    function automatic int sig_val(int s);
        case (s)
            0: return int'(count);
            1: return int'(zero_evt);
            2: return int'(prd_evt);
            3: return int'(sync_out);
            default: return int'(m_count);
        endcase
    endfunction

    // monitor: pops expected items as their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.cyc != cyc || sig_val(it.sig) != it.exp) begin
                errors++;
                $display("FAIL %s: signal %0d cycle %0d actual %0d expected %0d",
                         it.req, it.sig, it.cyc, sig_val(it.sig), it.exp);
            end
        end
    end

    task automatic push(int c, int s, int e, string r);
        item_t it;
        it.cyc = c; it.sig = s; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        tick(1);
    endtask

    task automatic restart();
        rst_n = 1'b0; run_en = 1'b0; cnt_mode = 1'b0; prd_wr = 1'b0;
        prd_din = '0; prd_ld_sel = 2'd0; phs_en = 1'b0; phs_val = '0;
        phs_dir_dn = 1'b0; so_sel = 2'd1; tb_sync = 1'b0; chain = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic sync_pulse();
        tb_sync = 1'b1;
        tick(1);
        tb_sync = 1'b0;
    endtask

    function automatic int tri_v(int k);
        int m = k % (2 * P);
        return (m <= P) ? m : 2 * P - m;
    endfunction

    initial begin
        int c;
        restart();
        // R1 reset state, R2 frozen while disabled
        c = cyc;
        push(c, 0, 0, "R1"); push(c, 1, 0, "R1"); push(c, 2, 0, "R1");
        push(c + 3, 0, 0, "R2");
        tick(4); drain();

        // R3 sawtooth, R5 strobes, R10 zero-driven sync out, R2 freeze mid-run
        run_en = 1'b1; c = cyc;
        for (int k = 0; k < 14; k++) begin
            push(c + k, 0, k % (P + 1), "R3");
            push(c + k, 1, int'(k % (P + 1) == 0), "R5");
            push(c + k, 2, int'(k % (P + 1) == P), "R5");
            push(c + k, 3, int'(k % (P + 1) == 0), "R10");
        end
        tick(14);
        run_en = 1'b0;
        for (int k = 1; k < 4; k++) begin
            push(c + 14 + k, 0, 14 % (P + 1), "R2");
            push(c + 14 + k, 1, 0, "R2");
        end
        tick(4); drain();

        // R4 triangle
        restart(); cnt_mode = 1'b1; run_en = 1'b1; c = cyc;
        for (int k = 0; k < 22; k++) begin
            push(c + k, 0, tri_v(k), "R4");
            push(c + k, 1, int'(tri_v(k) == 0), "R5");
            push(c + k, 2, int'(tri_v(k) == P), "R5");
        end
        tick(22); drain();

        // R6 transfer at zero
        restart(); run_en = 1'b1; prd_wr = 1'b1; prd_din = 8'd3; c = cyc;
        tick(1); prd_wr = 1'b0;
        push(c + 5, 0, 5, "R6"); push(c + 6, 0, 0, "R6");
        push(c + 9, 0, 3, "R6"); push(c + 10, 0, 0, "R6");
        tick(10); drain();

        // R6 transfer at write
        restart(); prd_ld_sel = 2'd2; run_en = 1'b1; prd_wr = 1'b1; prd_din = 8'd2; c = cyc;
        tick(1); prd_wr = 1'b0;
        push(c + 2, 0, 2, "R6"); push(c + 3, 0, 0, "R6");
        push(c + 5, 0, 2, "R6"); push(c + 6, 0, 0, "R6");
        tick(7); drain();

        // R6 transfer at sync, R8 sync ignored by counter without phase enable
        restart(); prd_ld_sel = 2'd1; run_en = 1'b1; prd_wr = 1'b1; prd_din = 8'd3; c = cyc;
        tick(1); prd_wr = 1'b0;
        tick(1); sync_pulse();
        push(c + 4, 0, 4, "R8"); push(c + 5, 0, 0, "R6");
        tick(4); drain();

        // R7 phase load in sawtooth
        restart(); phs_en = 1'b1; phs_val = 8'd1; run_en = 1'b1; c = cyc;
        tick(1); sync_pulse();
        push(c + 2, 0, 2, "R7"); push(c + 3, 0, 1, "R7"); push(c + 4, 0, 2, "R7");
        tick(4); drain();

        // R9 triangle, count down after load
        restart(); cnt_mode = 1'b1; phs_en = 1'b1; phs_val = 8'd4; phs_dir_dn = 1'b1;
        run_en = 1'b1; c = cyc;
        tick(1); sync_pulse();
        push(c + 3, 0, 4, "R9"); push(c + 4, 0, 3, "R9"); push(c + 5, 0, 2, "R9");
        tick(5); drain();

        // R9 triangle, count up after load
        restart(); cnt_mode = 1'b1; phs_en = 1'b1; phs_val = 8'd4; run_en = 1'b1; c = cyc;
        tick(1); sync_pulse();
        push(c + 3, 0, 4, "R9"); push(c + 4, 0, 5, "R9"); push(c + 5, 0, 4, "R9");
        tick(5); drain();

        // R10 pass-through and off
        restart(); so_sel = 2'd2; tb_sync = 1'b1; c = cyc;
        push(c, 3, 1, "R10");
        tick(1); tb_sync = 1'b0; so_sel = 2'd0; run_en = 1'b1;
        push(c + 1, 1, 1, "R10"); push(c + 1, 3, 0, "R10");
        tick(2); drain();

        // R11 chained, aligned, sawtooth
        restart(); chain = 1'b1; so_sel = 2'd2; phs_en = 1'b1; phs_val = W'(LAT);
        run_en = 1'b1; c = cyc;
        for (int k = 0; k < 20; k++) begin
            push(c + k, 0, k % (P + 1), "R11");
            push(c + k, 3, int'(k % (P + 1) == 0), "R10");
            push(c + k, 4, k % (P + 1), "R11");
        end
        tick(20); drain();

        // R11 chained, phase 0 gives constant lag
        restart(); chain = 1'b1; phs_en = 1'b1; phs_val = '0; run_en = 1'b1; c = cyc;
        for (int k = LAT; k < 20; k++) begin
            push(c + k, 0, (k - LAT) % (P + 1), "R11");
            push(c + k, 4, k % (P + 1), "R11");
        end
        tick(20); drain();

        // R11 chained, aligned, triangle
        restart(); chain = 1'b1; cnt_mode = 1'b1; phs_en = 1'b1; phs_val = W'(LAT);
        run_en = 1'b1; c = cyc;
        for (int k = 0; k < 24; k++) begin
            push(c + k, 0, tri_v(k), "R11");
            push(c + k, 4, tri_v(k), "R11");
        end
        tick(24); drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule